// File: doc/BRIEF.md
# Receive FIFO Character Timeout Timer

This block watches a UART receive FIFO and raises a timeout-pending flag when data has been left sitting in it. Data counts as stale when the FIFO holds at least one character and four full character times have gone by with no new character arriving and no CPU read of the FIFO. The window is measured in ticks of the 16x sample-clock enable, so it follows the baud rate. It also follows the programmed frame format: word length, parity and the number of stop bits.

The receive path drives the character strobe each time a character enters the FIFO. The host-side read logic drives the read strobe on each pop. The flag is intended to feed the receive-data interrupt source. Baud generation and FIFO storage sit outside this block.

Top module: `rxto_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `timeout_pend` is 0.
- R2: The length of one character in bit times is 1 start bit, plus `DATA_MIN + word_len` data bits (word_len 0..3 selects 5..8 bits by default), plus 1 when `parity_en` is 1, plus 1 stop bit when `two_stop` is 0 or 2 stop bits when it is 1.
- R3: After a restart, `timeout_pend` rises at the clock edge that takes the `WINDOW_CHARS * OVERSAMPLE * bits`-th `sample_en` pulse, where bits is the length from R2. It is 0 at every earlier edge.
- R4: A CPU read (`fifo_rd` high) clears `timeout_pend` and restarts the window. This holds whether or not a timeout is pending.
- R5: While no timeout is pending, a received character (`char_rcvd` high) restarts the window.
- R6: While a timeout is pending, a received character leaves `timeout_pend` at 1.
- R7: While `fifo_nonempty`, `fifo_en` or `rx_irq_en` is 0, `timeout_pend` is 0 and the timer is held at its restart value. Counting starts from zero once all three are 1 again.
- R8: Cycles without `sample_en` do not advance the timer, so `timeout_pend` can only rise on a cycle in which `sample_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO mode enabled |
| rx_irq_en | input | 1 | Receive interrupt enabled |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one character |
| sample_en | input | 1 | 16x sample-clock enable (OVERSAMPLE per bit time) |
| char_rcvd | input | 1 | One-cycle strobe: a character entered the FIFO |
| fifo_rd | input | 1 | One-cycle strobe: the CPU read the FIFO |
| word_len | input | WLEN_W | Data length code; data bits = DATA_MIN + word_len |
| parity_en | input | 1 | Parity bit present in the frame |
| two_stop | input | 1 | Second stop bit present in the frame |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
The bench builds the block with `OVERSAMPLE = 4` and `WINDOW_CHARS = 4`, keeping the default 5-bit minimum data length and 2-bit length code. The shorter oversampling ratio makes each window at most 192 enable pulses long. That makes it affordable to run the exact edge of the window, one pulse short and then the final pulse, for all sixteen frame formats. It also leaves room to slow the enable to one pulse in three cycles. With these values, the restarts, holds and sticky-pending cases can all be reached inside one window of the longest frame.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

   // Per-cycle control decoded from the enables and strobes
   typedef struct packed {
      logic hold;    // timer frozen at zero, flag dropped
      logic kill;    // flag dropped and timer restarted
      logic clear;   // timer restarted
      logic run;     // sample pulse allowed to advance the timer
   } rxto_ctrl_t;

   // Bit times in one frame: start + data + optional parity + stop bits
   function automatic int unsigned frame_bits(input int unsigned data_min,
                                              input int unsigned len_code,
                                              input logic        par,
                                              input logic        stop2);
      int unsigned b;
      b = 1 + data_min + len_code + 1;
      if (par)   b = b + 1;
      if (stop2) b = b + 1;
      return b;
   endfunction

endpackage

// File: rtl/rxto_frame_len.sv
module rxto_frame_len #(
   parameter int unsigned DATA_MIN     = 5,
   parameter int unsigned WLEN_W       = 2,
   parameter int unsigned WINDOW_CHARS = 4,
   parameter int unsigned LIM_W        = 6
) (
   input  logic [WLEN_W-1:0] word_len,
   input  logic              parity_en,
   input  logic              two_stop,
   output logic [LIM_W-1:0]  limit
);
   import rxto_pkg::*;

   always_comb begin
      limit = LIM_W'(WINDOW_CHARS *
                     frame_bits(DATA_MIN, 32'(word_len), parity_en, two_stop));
   end

endmodule

// File: rtl/rxto_prescaler.sv
module rxto_prescaler #(
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic bit_tick
);

   generate
      if (OVERSAMPLE == 1) begin : g_direct
         assign bit_tick = run;

         AST_DIRECT_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            clear |-> !bit_tick) else $error("tick during clear"); // R5
      end else begin : g_div
         localparam int unsigned PW = $clog2(OVERSAMPLE);
         logic [PW-1:0] phase;
         logic          wrap;

         assign wrap     = (phase == PW'(OVERSAMPLE - 1));
         assign bit_tick = run & wrap;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      phase <= '0;
            else if (clear)  phase <= '0;
            else if (run)    phase <= wrap ? '0 : phase + 1'b1;
         end

         AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            {1'b0, phase} < (PW+1)'(OVERSAMPLE)) else $error("phase out of range"); // R3
         AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
            clear |=> phase == '0) else $error("phase not restarted"); // R5
      end
   endgenerate

endmodule

// File: rtl/rxto_window_cnt.sv
module rxto_window_cnt #(
   parameter int unsigned LIM_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             bit_tick,
   input  logic [LIM_W-1:0] limit,
   output logic             reach
);
   logic [LIM_W-1:0] cnt;
   logic [LIM_W:0]   nxt;

   assign nxt   = {1'b0, cnt} + 1'b1;
   assign reach = bit_tick && (nxt >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (clear)     cnt <= '0;
      else if (reach)     cnt <= limit;
      else if (bit_tick)  cnt <= nxt[LIM_W-1:0];
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick && !clear |=> cnt != '0) else $error("window count wrapped"); // R3

endmodule

// File: rtl/rxto_timer.sv
module rxto_timer #(
   parameter int unsigned OVERSAMPLE   = 16,
   parameter int unsigned WINDOW_CHARS = 4,
   parameter int unsigned DATA_MIN     = 5,
   parameter int unsigned WLEN_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              rx_irq_en,
   input  logic              fifo_nonempty,
   input  logic              sample_en,
   input  logic              char_rcvd,
   input  logic              fifo_rd,
   input  logic [WLEN_W-1:0] word_len,
   input  logic              parity_en,
   input  logic              two_stop,
   output logic              timeout_pend
);
   import rxto_pkg::*;

   localparam int unsigned DATA_MAX = DATA_MIN + (1 << WLEN_W) - 1;
   localparam int unsigned MAX_BITS = DATA_MAX + 4;
   localparam int unsigned LIM_MAX  = WINDOW_CHARS * MAX_BITS;
   localparam int unsigned LIM_W    = $clog2(LIM_MAX + 1);

   generate
      if (OVERSAMPLE < 1) begin : g_bad_ovs
         $error("OVERSAMPLE must be at least 1");
      end
      if (WINDOW_CHARS < 1) begin : g_bad_win
         $error("WINDOW_CHARS must be at least 1");
      end
      if (DATA_MIN < 1) begin : g_bad_dmin
         $error("DATA_MIN must be at least 1");
      end
      if (WLEN_W < 1 || WLEN_W > 4) begin : g_bad_wlen
         $error("WLEN_W must lie in 1..4");
      end
   endgenerate

   rxto_ctrl_t       ctrl;
   logic [LIM_W-1:0] limit;
   logic             bit_tick;
   logic             reach;

   always_comb begin
      ctrl.hold  = ~fifo_en | ~rx_irq_en | ~fifo_nonempty;
      ctrl.kill  = ctrl.hold | fifo_rd;
      ctrl.clear = ctrl.kill | (char_rcvd & ~timeout_pend);
      ctrl.run   = sample_en & ~timeout_pend & ~ctrl.clear;
   end

   rxto_frame_len #(
      .DATA_MIN     (DATA_MIN),
      .WLEN_W       (WLEN_W),
      .WINDOW_CHARS (WINDOW_CHARS),
      .LIM_W        (LIM_W)
   ) i_frame_len (
      .word_len  (word_len),
      .parity_en (parity_en),
      .two_stop  (two_stop),
      .limit     (limit)
   );

   rxto_prescaler #(
      .OVERSAMPLE (OVERSAMPLE)
   ) i_prescaler (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (ctrl.clear),
      .run      (ctrl.run),
      .bit_tick (bit_tick)
   );

   rxto_window_cnt #(
      .LIM_W (LIM_W)
   ) i_window_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (ctrl.clear),
      .bit_tick (bit_tick),
      .limit    (limit),
      .reach    (reach)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          timeout_pend <= 1'b0;
      else if (ctrl.kill)  timeout_pend <= 1'b0;
      else if (reach)      timeout_pend <= 1'b1;
   end

   AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.hold |=> !timeout_pend) else $error("pending while held"); // R7
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |=> !timeout_pend) else $error("pending after read"); // R4
   AST_CHAR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pend && char_rcvd && !fifo_rd && !ctrl.hold |=> timeout_pend)
      else $error("character cleared pending"); // R6
   AST_RISE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_pend) |-> $past(sample_en)) else $error("rose without sample"); // R8
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en && !fifo_rd && !ctrl.hold |=> $stable(timeout_pend))
      else $error("flag moved on idle cycle"); // R8

endmodule

// File: tb/test_rxto_timer.sv
`timescale 1ns/1ps
module test_rxto_timer;
   localparam int OVS = 4;
   localparam int WIN = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b1, rx_irq_en = 1'b1, fifo_nonempty = 1'b0;
   logic       sample_en = 1'b0, char_rcvd = 1'b0, fifo_rd = 1'b0;
   logic [1:0] word_len = 2'd0;
   logic       parity_en = 1'b0, two_stop = 1'b0;
   logic       timeout_pend;

   always #10 clk = ~clk;

   rxto_timer #(.OVERSAMPLE(OVS), .WINDOW_CHARS(WIN)) i_rxto_timer (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_irq_en(rx_irq_en),
      .fifo_nonempty(fifo_nonempty), .sample_en(sample_en), .char_rcvd(char_rcvd),
      .fifo_rd(fifo_rd), .word_len(word_len), .parity_en(parity_en),
      .two_stop(two_stop), .timeout_pend(timeout_pend));

   int    vectors = 0, errors = 0;
   bit    done = 0;
   int    m_samples = 0;
   bit    m_pend = 0;
   string tag = "R1";

   // R2: bit times per frame
   function automatic int char_bits(int wl, bit p, bit s2);
      return 1 + (5 + wl) + (p ? 1 : 0) + (s2 ? 2 : 1);
   endfunction

   function automatic int window();
      return WIN * OVS * char_bits(int'(word_len), parity_en, two_stop);
   endfunction

   // Behavioural reference: count raw sample pulses since the last restart
   always @(posedge clk) begin
      if (!rst_n) begin
         m_samples = 0; m_pend = 0;
      end else if (!fifo_en || !rx_irq_en || !fifo_nonempty || fifo_rd) begin
         m_samples = 0; m_pend = 0;
      end else if (char_rcvd && !m_pend) begin
         m_samples = 0;
      end else if (!m_pend && sample_en) begin
         m_samples++;
         if (m_samples >= window()) m_pend = 1;
      end
   end

   task automatic tick(input bit s, input bit c, input bit r);
      sample_en = s; char_rcvd = c; fifo_rd = r;
      @(posedge clk);
      @(negedge clk);
      sample_en = 0; char_rcvd = 0; fifo_rd = 0;
      vectors++;
      if (timeout_pend !== m_pend) begin
         errors++;
         $display("FAIL %s model compare: actual %0b expected %0b", tag, timeout_pend, m_pend);
      end
   endtask

   task automatic expect_pend(input bit e, input string t);
      vectors++;
      if (timeout_pend !== e) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", t, timeout_pend, e);
      end
   endtask

   task automatic pulses(input int n);
      repeat (n) tick(1, 0, 0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
   endtask

   initial begin
      int w;
      repeat (3) @(negedge clk);
      expect_pend(0, "R1 during reset");
      rst_n = 1'b1;
      tick(0, 0, 0);
      expect_pend(0, "R1 after reset");

      // R2 / R3 / R4: exact window for every frame format
      fifo_nonempty = 1'b1;
      for (int f = 0; f < 16; f++) begin
         word_len = 2'(f); parity_en = f[2]; two_stop = f[3];
         tag = "R2";
         tick(0, 1, 0);
         w = WIN * OVS * char_bits(f % 4, f[2], f[3]);
         pulses(w - 1);
         expect_pend(0, "R3 one pulse short");
         tick(1, 0, 0);
         expect_pend(1, "R2 window length");
         tag = "R4";
         tick(0, 0, 1);
         expect_pend(0, "R4 read clears");
      end

      // R8: sparse sample enable
      word_len = 2'd3; parity_en = 1; two_stop = 1;
      w = window();
      tag = "R8";
      tick(0, 1, 0);
      for (int i = 0; i < w - 1; i++) begin
         tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
      end
      repeat (20) tick(0, 0, 0);
      expect_pend(0, "R8 idle cycles do not count");
      tick(1, 0, 0);
      expect_pend(1, "R8 final pulse");
      tick(0, 0, 1);

      // R5: new character restarts the window
      tag = "R5";
      word_len = 2'd1; parity_en = 0; two_stop = 1;
      w = window();
      pulses(w / 2);
      tick(0, 1, 0);
      pulses(w - 1);
      expect_pend(0, "R5 restart by character");
      tick(1, 0, 0);
      expect_pend(1, "R5 expiry after restart");

      // R6: character while pending keeps flag
      tag = "R6";
      tick(0, 1, 0);
      expect_pend(1, "R6 character keeps pending");
      pulses(5);
      expect_pend(1, "R6 still pending");

      // R4: read while not pending restarts
      tag = "R4";
      tick(0, 0, 1);
      pulses(w / 2);
      tick(0, 0, 1);
      pulses(w - 1);
      expect_pend(0, "R4 restart by read");
      tick(1, 0, 0);
      expect_pend(1, "R4 expiry after read restart");

      // R7: holds
      tag = "R7";
      fifo_nonempty = 0;
      tick(0, 0, 0);
      expect_pend(0, "R7 empty clears");
      pulses(w + 5);
      expect_pend(0, "R7 empty holds");
      fifo_nonempty = 1;
      pulses(w / 2);
      fifo_nonempty = 0; tick(1, 0, 0); fifo_nonempty = 1;
      pulses(w - 1);
      expect_pend(0, "R7 hold restarts timer");
      tick(1, 0, 0);
      expect_pend(1, "R7 counts after hold");
      fifo_en = 0;
      tick(0, 0, 0);
      expect_pend(0, "R7 fifo disabled clears");
      pulses(w + 5);
      expect_pend(0, "R7 fifo disabled holds");
      fifo_en = 1; rx_irq_en = 0;
      pulses(w + 5);
      expect_pend(0, "R7 irq disabled holds");
      rx_irq_en = 1;
      pulses(w - 1);
      expect_pend(0, "R7 restart after enable");
      tick(1, 0, 0);
      expect_pend(1, "R7 expiry after enable");

      done = 1;
      summary();
      $finish;
   end

   initial begin
      #(20.0 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

endmodule